// File: doc/BRIEF.md
# Sigma-Delta DC Measurement Sequencer

This block runs a DC measurement on the one-bit output stream of a first-order sigma-delta encoder. It contains an integrate-and-dump decimator and the state machine that drives it. The decimator adds +1 for every encoder `1` and -1 for every `0`. The state machine decides when that storage is cleared, when it accumulates and whether its input is inverted. After exactly D accumulated samples it reports a signed sum together with a one-cycle done pulse.

Accumulation can start in one of two ways. In wait mode the block holds off until the encoder bit has changed value once, which guarantees that the encoder state lies inside its stable range. This mode needs a decimation length of about 2b/ε for full scale b and error ε; with b = 1 and ε = 0.001 that is 2000 cycles. In preset mode the block sends a one-cycle request that loads the encoder integrator with its input value, then starts at once. The error bound is halved, so D of about b/ε (1000 cycles) is enough.

A difference run skips the clear and weights the samples inverted. The stored sum of the previous run therefore becomes the first level minus the second, which is useful for static converter tests.

Top module: `sdm_dc_seq`

## Requirements
- R1: While reset is asserted and just after it is released, busy_o, done_o, preset_o, acc_clr_o, acc_en_o and acc_inv_o are 0, and result_o is 0.
- R2: start_i is accepted only when busy_o is 0. mode_preset_i, diff_i and dec_len_i are sampled only in the accepting cycle. A start pulse or a change of those inputs during a run has no effect on that run's result or timing.
- R3: In a normal run (diff_i = 0), acc_clr_o is high for exactly the one cycle after the accepting cycle, and the decimator sum is set to zero.
- R4: In wait mode (mode_preset_i = 0), the encoder bit is sampled once per cycle in the arming phase. The first sampled bit only sets up the comparison. Accumulation starts in the cycle after the first sample that differs from the one before it, and a change between the bit seen before the run and the first sampled bit does not count.
- R5: In preset mode (mode_preset_i = 1), preset_o is high for exactly one cycle: the cycle after the clear in a normal run, or the cycle after acceptance in a difference run. Accumulation starts in the next cycle, whatever the encoder bit does. preset_o is never high in wait mode.
- R6: acc_en_o is high for exactly D consecutive cycles, where D is dec_len_i sampled at acceptance and a value of 0 is treated as 1. Each enabled cycle adds +1 for bit_i = 1 and -1 for bit_i = 0 to the sum.
- R7: In a difference run (diff_i = 1) there is no clear cycle, and acc_inv_o is high for the whole run. Each enabled cycle adds -1 for bit_i = 1 and +1 for bit_i = 0, so the final sum is the previous sum minus the new run's sum.
- R8: done_o is high for one cycle, directly after the last enabled cycle. In that same cycle result_o shows the final signed sum, and result_o keeps that value until the next done pulse. busy_o falls in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted only when the block is idle |
| mode_preset_i | input | 1 | 1: start with an integrator preset; 0: wait for the first bit change |
| diff_i | input | 1 | 1: difference run (no clear, inverted weighting) |
| dec_len_i | input | CNT_W | Decimation length D (0 is treated as 1) |
| bit_i | input | 1 | One-bit encoder output |
| preset_o | output | 1 | One-cycle request to load the encoder integrator |
| acc_clr_o | output | 1 | Decimator clear strobe |
| acc_en_o | output | 1 | Decimator accumulate enable |
| acc_inv_o | output | 1 | Decimator input inversion |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | ACC_W | Signed decimator sum, held between completions |

## Verification
A wrong state in the sequencer shows up at the ports within one cycle as a misplaced strobe: a clear pulse in a difference run, a missing or doubled preset request, or an enable that rises before a bit change. It also shows up at the end of the run as a done pulse in the wrong cycle. A wrong transition detector or a wrong window length moves the window of accumulated samples. The stimulus patterns are chosen so that such a shift changes the signed result, and a miscounted window also moves the done cycle. Difference runs chain on the stored sum, so a clear that should not happen, or a wrong sign, shows up in the next result.

// File: rtl/sdm_dc_pkg.sv
package sdm_dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ARM,
    ST_ACCUM,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sdm_edge_det.sv
module sdm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic sample_i,
  input  logic bit_i,
  output logic edge_o
);
  logic prev_q;
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (init_i) begin
      vld_q  <= 1'b0;
    end else if (sample_i) begin
      prev_q <= bit_i;
      vld_q  <= 1'b1;
    end
  end

  // first sample only seeds prev_q
  assign edge_o = sample_i && vld_q && (bit_i != prev_q);
endmodule

// File: rtl/sdm_run_cnt.sv
module sdm_run_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             step_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= ONE;
      cnt_q <= '0;
    end else if (load_i) begin
      len_q <= (len_i == '0) ? ONE : len_i;
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign last_o = step_i && (cnt_q == len_q - ONE);
endmodule

// File: rtl/sdm_accum.sv
module sdm_accum #(
  parameter int ACC_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    inv_i,
  input  logic                    bit_i,
  input  logic                    dump_i,
  output logic signed [ACC_W-1:0] result_o
);
  localparam logic signed [ACC_W-1:0] POS = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] NEG = -POS;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [ACC_W-1:0] res_q;

  assign acc_nxt = acc_q + ((bit_i ^ inv_i) ? POS : NEG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (clr_i)     acc_q <= '0;
      else if (en_i) acc_q <= acc_nxt;
      if (dump_i)    res_q <= acc_nxt;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/sdm_dc_seq.sv
module sdm_dc_seq
  import sdm_dc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ACC_W = CNT_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    mode_preset_i,
  input  logic                    diff_i,
  input  logic [CNT_W-1:0]        dec_len_i,
  input  logic                    bit_i,
  output logic                    preset_o,
  output logic                    acc_clr_o,
  output logic                    acc_en_o,
  output logic                    acc_inv_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] result_o
);
  seq_state_e state_q, state_d;
  logic       preset_q;
  logic       diff_q;
  logic       start_ok;
  logic       bit_edge;
  logic       last_smp;

  assign start_ok = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      preset_q <= 1'b0;
      diff_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        preset_q <= mode_preset_i;
        diff_q   <= diff_i;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok) state_d = diff_i ? ST_ARM : ST_CLEAR;
      ST_CLEAR: state_d = ST_ARM;
      ST_ARM:   if (preset_q || bit_edge) state_d = ST_ACCUM;
      ST_ACCUM: if (last_smp) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign acc_clr_o = (state_q == ST_CLEAR);
  assign acc_en_o  = (state_q == ST_ACCUM);
  assign preset_o  = (state_q == ST_ARM) && preset_q;
  assign acc_inv_o = (state_q != ST_IDLE) && diff_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);

  sdm_edge_det u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (start_ok),
    .sample_i ((state_q == ST_ARM) && !preset_q),
    .bit_i    (bit_i),
    .edge_o   (bit_edge)
  );

  sdm_run_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_ok),
    .len_i  (dec_len_i),
    .step_i (acc_en_o),
    .last_o (last_smp)
  );

  sdm_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (acc_clr_o),
    .en_i     (acc_en_o),
    .inv_i    (acc_inv_o),
    .bit_i    (bit_i),
    .dump_i   (last_smp),
    .result_o (result_o)
  );
endmodule

// File: rtl/sdm_dc_seq_chk.sv
module sdm_dc_seq_chk #(
  parameter int CNT_W = 16,
  parameter int ACC_W = CNT_W + 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    mode_preset_i,
  input logic                    diff_i,
  input logic [CNT_W-1:0]        dec_len_i,
  input logic                    bit_i,
  input logic                    preset_o,
  input logic                    acc_clr_o,
  input logic                    acc_en_o,
  input logic                    acc_inv_o,
  input logic                    busy_o,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] result_o
);
  logic [CNT_W:0] en_cnt_q;
  logic [CNT_W:0] len_q;
  logic           wait_run_q;
  logic           accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_cnt_q   <= '0;
      len_q      <= '0;
      wait_run_q <= 1'b0;
    end else if (accept) begin
      en_cnt_q   <= '0;
      len_q      <= (dec_len_i == '0) ? (CNT_W+1)'(1) : {1'b0, dec_len_i};
      wait_run_q <= !mode_preset_i;
    end else if (acc_en_o) begin
      en_cnt_q <= en_cnt_q + 1'b1;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);

  // R3
  clear_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !diff_i) |=> acc_clr_o);

  // R3
  clear_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_clr_o |=> !acc_clr_o);

  // R4
  wait_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(acc_en_o) && wait_run_q) |-> ($past(bit_i) != $past(bit_i, 2)));

  // R5
  preset_then_accum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_o |=> (acc_en_o && !preset_o));

  // R5
  no_preset_in_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wait_run_q) |-> !preset_o);

  // R6
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (en_cnt_q == len_q));

  // R7
  diff_no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && diff_i) |=> (!acc_clr_o && acc_inv_o));

  // R7
  inv_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_inv_o |-> busy_o);

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

bind sdm_dc_seq sdm_dc_seq_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .mode_preset_i (mode_preset_i),
  .diff_i        (diff_i),
  .dec_len_i     (dec_len_i),
  .bit_i         (bit_i),
  .preset_o      (preset_o),
  .acc_clr_o     (acc_clr_o),
  .acc_en_o      (acc_en_o),
  .acc_inv_o     (acc_inv_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .result_o      (result_o)
);

// File: tb/sdm_dc_seq_tb.sv
module sdm_dc_seq_tb;
  localparam int CNT_W = 16;
  localparam int ACC_W = CNT_W + 2;
  localparam int NV    = 10;

  // {preset, diff, D[15:0], lead[7:0], word[15:0]}
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'd16,   8'd5, 16'hF0F0},
    {1'b1, 1'b0, 16'd16,   8'd3, 16'hFFF0},
    {1'b0, 1'b0, 16'd10,   8'd2, 16'h5555},
    {1'b0, 1'b1, 16'd10,   8'd4, 16'hAAAA},
    {1'b1, 1'b0, 16'd8,    8'd0, 16'hFFFF},
    {1'b1, 1'b1, 16'd8,    8'd0, 16'h00FF},
    {1'b0, 1'b0, 16'd1,    8'd6, 16'h0001},
    {1'b0, 1'b0, 16'd0,    8'd3, 16'h3C3C},
    {1'b0, 1'b0, 16'd2000, 8'd7, 16'hEEEE},
    {1'b1, 1'b0, 16'd1000, 8'd0, 16'h6DB6}
  };

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    start_i = 1'b0;
  logic                    mode_preset_i = 1'b0;
  logic                    diff_i = 1'b0;
  logic [CNT_W-1:0]        dec_len_i = '0;
  logic                    bit_i = 1'b0;
  logic                    preset_o, acc_clr_o, acc_en_o, acc_inv_o, busy_o, done_o;
  logic signed [ACC_W-1:0] result_o;

  int checks = 0;
  int failures = 0;
  int model_acc = 0;

  always #2 clk_i = ~clk_i;

  sdm_dc_seq #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_preset_i(mode_preset_i),
    .diff_i(diff_i), .dec_len_i(dec_len_i), .bit_i(bit_i), .preset_o(preset_o),
    .acc_clr_o(acc_clr_o), .acc_en_o(acc_en_o), .acc_inv_o(acc_inv_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic gen_bit(input int idx, input logic [7:0] lead, input logic [15:0] w);
    if (idx < int'(lead)) return ~w[0];
    return w[(idx - int'(lead)) % 16];
  endfunction

  task automatic run_meas(input logic pre, input logic dif, input logic [15:0] dlen,
                          input logic [7:0] lead, input logic [15:0] w, input bit stray);
    int deff, arm0, acc0, t, s, done_idx, pre_idx, clr_idx, inv_cnt;
    deff = (dlen == 0) ? 1 : int'(dlen);
    arm0 = dif ? 0 : 1;
    if (pre) acc0 = arm0 + 1;
    else begin
      t = arm0 + 1;
      while (gen_bit(t, lead, w) == gen_bit(t - 1, lead, w)) t++;
      acc0 = t + 1;
    end
    s = 0;
    for (int k = acc0; k < acc0 + deff; k++)
      s += (gen_bit(k, lead, w) ^ dif) ? 1 : -1;
    model_acc = dif ? model_acc + s : s;

    @(negedge clk_i);
    start_i = 1'b1; mode_preset_i = pre; diff_i = dif; dec_len_i = dlen;
    bit_i = ~gen_bit(0, lead, w);
    done_idx = -1; pre_idx = -1; clr_idx = -1; inv_cnt = 0;
    for (int idx = 0; idx < 5000 && done_idx < 0; idx++) begin
      @(negedge clk_i);
      start_i = stray && (idx == 3);
      mode_preset_i = ~pre; diff_i = ~dif; dec_len_i = dlen + 16'd3;
      bit_i = gen_bit(idx, lead, w);
      if (preset_o) pre_idx = (pre_idx < 0) ? idx : 9999;
      if (acc_clr_o) clr_idx = (clr_idx < 0) ? idx : 9999;
      if (acc_inv_o) inv_cnt++;
      if (done_o) done_idx = idx;
    end
    check(done_idx == acc0 + deff, "R6 done cycle", done_idx, acc0 + deff);
    check(result_o == ACC_W'(model_acc), dif ? "R7 diff result" : "R4/R5/R6 result",
          int'(result_o), model_acc);
    check(clr_idx == (dif ? -1 : 0), "R3 clear pulse", clr_idx, dif ? -1 : 0);
    check(pre_idx == (pre ? arm0 : -1), "R5 preset pulse", pre_idx, pre ? arm0 : -1);
    if (dif) check(inv_cnt == done_idx + 1, "R7 invert active", inv_cnt, done_idx + 1);
    start_i = 1'b0;
    @(negedge clk_i);
    check(!done_o && !busy_o, "R8 done one cycle", {done_o, busy_o}, 0);
    repeat (4) @(negedge clk_i);
    check(result_o == ACC_W'(model_acc), "R8 result held", int'(result_o), model_acc);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({busy_o, done_o, preset_o, acc_clr_o, acc_en_o, acc_inv_o} == 6'b0,
          "R1 reset outputs", {busy_o, done_o, preset_o, acc_clr_o, acc_en_o, acc_inv_o}, 0);
    check(result_o == '0, "R1 reset result", int'(result_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && result_o == '0, "R1 after release", int'(result_o), 0);

    for (int v = 0; v < NV; v++)
      run_meas(VEC[v][41], VEC[v][40], VEC[v][39:24], VEC[v][23:16], VEC[v][15:0], 1'b0);

    // R2: stray start and changed mode inputs in mid-run are ignored
    run_meas(1'b0, 1'b0, 16'd12, 8'd4, 16'hC3A5, 1'b1);
    run_meas(1'b1, 1'b1, 16'd12, 8'd0, 16'h0F0F, 1'b1);

    // R4: long steady lead ahead of the first change
    run_meas(1'b0, 1'b0, 16'd20, 8'd40, 16'h9249, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule